// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block is the bus-facing core of an I2C master. Software steers it through a small register window: a control word that holds an enable bit, a two-bit command field and an acknowledge-select bit; a data register whose write sends one byte; a status register with a session-done flag; and a pad register that can switch the bus outputs off. The engine produces start, repeated-start and stop conditions and single-byte writes. After each byte it reports whether the target acknowledged.

SCL and SDA are open-drain. The engine only ever pulls a line low or releases it, through the `scl_oe` and `sda_oe` enables, and reads SDA back through `sda_in`. Timing comes from a divider that emits one tick every `DIV` clocks. Every bus action takes place on a tick, and four ticks make one bit period. A command is launched when the command field changes from no action to a valid code. Software must return the field to no action before it issues the next command.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both line enables are 0 (lines released), `done_irq` is 0, the control word (read address 0) reads 0 and the pad register (read address 3) reads 1.
- R2: Pad register bit 0 (write address 3) set to 1 forces `scl_oe` and `sda_oe` to 0. Set to 0, it lets the engine's line state through, so a held-low SCL drives `scl_oe` to 1 again.
- R3: A control write with enable (bit 0) = 1, command (bits 2:1) = 1 and ack-select (bit 3) = 0 issued from an idle bus makes SDA fall while SCL is high, then pulls SCL low.
- R4: The same command with ack-select = 1 issued while SCL is low releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low.
- R5: Command code 2 pulls SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high.
- R6: A write to the data register (address 1) sends the byte MSB first. SDA changes only while SCL is low, so the byte produces no start or stop condition on the bus.
- R7: On the ninth clock SDA is released and sampled while SCL is high. Control bit 3 then reads 1 for NAK (SDA high) and 0 for ACK (SDA low).
- R8: The end of each command or byte sets the session-done flag (status bit 0, address 2), which `done_irq` mirrors. Writing 1 to status bit 0 clears it.
- R9: A command is launched only when the stored command field is 0 and the written code is 1 or 2. A repeated non-zero write, and code 3, do nothing.
- R10: With the enable bit at 0, command writes and data writes launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data, 2 status, 3 pad |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done_irq | output | 1 | Session-done flag |

## Verification
The bench turns the resolved line levels into start, stop and sampled-bit events and matches them against an expected stream. Each failure mode below shows up as a specific error:
- A repeated start that skips the release phase shows an SDA edge while SCL is low instead of the expected high bit followed by a start.
- A byte that moves SDA while SCL is high shows spurious start or stop events.
- A wrong bit order shows as mismatched bits.
- A target model answers ACK or NAK on the ninth clock, so an engine that samples in the wrong phase or inverts the reported bit misreports the result.
- Repeated non-zero commands, code 3 and disabled writes are issued while the bench watches for any bus activity or a done flag, so a design that relaunches on them is caught.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done_irq
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [5:0] BYTE_LAST = 6'd35;

  typedef enum logic [1:0] {OP_IDLE, OP_COND, OP_STOP, OP_BYTE} op_t;

  op_t         op;
  logic [5:0]  ph;
  logic [7:0]  sh;
  logic [CW-1:0] cnt;
  logic        en_q, nak_q, pad_dis, done_q, scl_rel, sda_rel;
  logic [1:0]  cmd_q;
  logic        busy, byte_act, tick, last, fin;
  logic        ctl_wr, dat_wr, st_wr, pad_wr, go_cmd, go_byte;

  assign busy     = (op != OP_IDLE);
  assign byte_act = (op == OP_BYTE);
  assign tick     = busy && (cnt == CW'(DIV - 1));
  assign ctl_wr   = wr_en && (wr_addr == 2'd0);
  assign dat_wr   = wr_en && (wr_addr == 2'd1);
  assign st_wr    = wr_en && (wr_addr == 2'd2);
  assign pad_wr   = wr_en && (wr_addr == 2'd3);
  assign go_cmd   = ctl_wr && !busy && wr_data[0] && (cmd_q == 2'd0) &&
                    (wr_data[2:1] == 2'd1 || wr_data[2:1] == 2'd2);
  assign go_byte  = dat_wr && !busy && en_q;

  always_comb begin
    case (op)
      OP_COND: last = (ph == 6'd3);
      OP_STOP: last = (ph == 6'd2);
      OP_BYTE: last = (ph == BYTE_LAST);
      default: last = 1'b0;
    endcase
  end
  assign fin = tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!busy || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cmd_q <= 2'd0; nak_q <= 1'b0;
      pad_dis <= 1'b1; done_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q  <= wr_data[0];
        cmd_q <= wr_data[2:1];
        nak_q <= wr_data[3];
      end else if (tick && byte_act && ph[5:2] == 4'd8 && ph[1:0] == 2'd2) begin
        nak_q <= sda_in;
      end
      if (pad_wr) pad_dis <= wr_data[0];
      if (fin) done_q <= 1'b1;
      else if (st_wr && wr_data[0]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_IDLE; ph <= '0; sh <= '0;
      scl_rel <= 1'b1; sda_rel <= 1'b1;
    end else if (go_cmd) begin
      op <= (wr_data[2:1] == 2'd2) ? OP_STOP : OP_COND;
      ph <= (wr_data[2:1] == 2'd1 && !wr_data[3]) ? 6'd2 : 6'd0;
    end else if (go_byte) begin
      op <= OP_BYTE;
      ph <= '0;
      sh <= wr_data;
    end else if (tick) begin
      ph <= ph + 1'b1;
      if (last) op <= OP_IDLE;
      case (op)
        OP_COND:
          case (ph[1:0])
            2'd0: sda_rel <= 1'b1;
            2'd1: scl_rel <= 1'b1;
            2'd2: sda_rel <= 1'b0;
            default: scl_rel <= 1'b0;
          endcase
        OP_STOP:
          case (ph[1:0])
            2'd0: sda_rel <= 1'b0;
            2'd1: scl_rel <= 1'b1;
            default: sda_rel <= 1'b1;
          endcase
        OP_BYTE:
          case (ph[1:0])
            2'd0: sda_rel <= (ph[5:2] == 4'd8) ? 1'b1 : sh[7];
            2'd1: scl_rel <= 1'b1;
            2'd2: ;
            default: begin
              scl_rel <= 1'b0;
              sh <= {sh[6:0], 1'b0};
            end
          endcase
        default: ;
      endcase
    end
  end

  assign scl_oe   = !pad_dis && !scl_rel;
  assign sda_oe   = !pad_dis && !sda_rel;
  assign done_irq = done_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {4'd0, nak_q, cmd_q, en_q};
      2'd2:    rd_data = {7'd0, done_q};
      2'd3:    rd_data = {7'd0, pad_dis};
      default: rd_data = 8'd0;
    endcase
  end
endmodule

module i2c_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done_irq,
  input logic       busy,
  input logic       byte_act,
  input logic       fin,
  input logic [1:0] cmd_q,
  input logic       en_q
);
  p_pad_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[0]) |=> (!scl_oe && !sda_oe));

  p_sda_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_act && $past(byte_act) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(busy));

  p_done_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && wr_data[0] && !fin) |=> !done_irq);

  p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd0 && cmd_q != 2'd0) |=> !busy);

  p_code3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd0 && wr_data[2:1] == 2'd3) |=> !busy);

  p_en_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd0 && !wr_data[0]) |=> !busy);

  p_en_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 2'd1 && !en_q) |=> !busy);
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .done_irq(done_irq), .busy(busy),
  .byte_act(byte_act), .fin(fin), .cmd_q(cmd_q), .en_q(en_q)
);

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int EV_START = 0, EV_STOP = 1, EV_B0 = 2, EV_B1 = 3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic scl_oe, sda_oe, done_irq, sda_in;
  logic slave_pull = 0;

  int vectors = 0, errors = 0;
  int exp_ev[$];
  string exp_req[$];
  bit mon_off = 0, in_byte = 0, ack_want = 0;
  int nrise = 0;
  bit prev_scl = 1, prev_sda = 1;

  assign sda_in = ~sda_oe & ~slave_pull;

  i2c_cmd_engine #(.DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done_irq(done_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic got(int ev);
    vectors++;
    if (exp_ev.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected bus event act=%0d exp=none", ev);
    end else begin
      int e = exp_ev.pop_front();
      string r = exp_req.pop_front();
      if (e != ev) begin
        errors++;
        $display("FAIL %s bus event act=%0d exp=%0d", r, ev, e);
      end
    end
  endtask

  always @(negedge clk) begin
    bit scl_b, sda_b;
    scl_b = ~scl_oe;
    sda_b = ~sda_oe & ~slave_pull;
    if (rst_n && !mon_off) begin
      if (scl_b && prev_scl && sda_b != prev_sda) got(sda_b ? EV_STOP : EV_START);
      if (scl_b && !prev_scl) begin
        got(sda_b ? EV_B1 : EV_B0);
        if (in_byte) nrise++;
      end
      if (!scl_b && prev_scl && in_byte) begin
        if (nrise == 8) slave_pull = ack_want;
        else if (nrise == 9) begin slave_pull = 0; in_byte = 0; end
      end
    end
    prev_scl = scl_b;
    prev_sda = ~sda_oe & ~slave_pull;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a; #1;
    d = rd_data;
  endtask

  task automatic push(int ev, string r);
    exp_ev.push_back(ev);
    exp_req.push_back(r);
  endtask

  task automatic finish_op(string r);
    logic [7:0] v;
    while (!done_irq) @(negedge clk);
    rd(2'd2, v);
    chk("R8", {"done set after ", r}, v[0], 1);
    wr(2'd2, 8'h01);
    @(negedge clk);
    chk("R8", "done cleared by W1C", done_irq, 0);
  endtask

  task automatic do_cmd(bit [1:0] code, bit ack, string r);
    wr(2'd0, {4'd0, ack, code, 1'b1});
    finish_op(r);
    wr(2'd0, 8'h01);
  endtask

  task automatic do_byte(logic [7:0] b, bit ack, string r);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) push(b[i] ? EV_B1 : EV_B0, "R6");
    push(ack ? EV_B0 : EV_B1, "R7");
    nrise = 0; ack_want = ack; in_byte = 1;
    wr(2'd1, b);
    finish_op(r);
    rd(2'd0, v);
    chk("R7", "nak bit", v[3], ack ? 0 : 1);
  endtask

  task automatic quiet(string r);
    repeat (100) @(negedge clk);
    chk(r, "no done flag", done_irq, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "done_irq", done_irq, 0);
    rd(2'd0, v); chk("R1", "ctl", v, 0);
    rd(2'd3, v); chk("R1", "pad", v, 1);

    wr(2'd3, 8'h00);
    @(negedge clk);
    chk("R2", "idle scl_oe released", scl_oe, 0);

    push(EV_START, "R3");
    do_cmd(2'd1, 1'b0, "start");
    chk("R3", "scl held low", scl_oe, 1);
    do_byte(8'hA5, 1'b1, "byte A5");
    push(EV_B1, "R4"); push(EV_START, "R4");
    do_cmd(2'd1, 1'b1, "restart");
    do_byte(8'h3C, 1'b0, "byte 3C");
    push(EV_B0, "R5"); push(EV_STOP, "R5");
    do_cmd(2'd2, 1'b0, "stop");
    chk("R5", "lines released", scl_oe | sda_oe, 0);

    push(EV_START, "R3");
    wr(2'd0, 8'h03);
    finish_op("start2");
    wr(2'd0, 8'h03);
    quiet("R9");
    wr(2'd0, 8'h05);
    quiet("R9");
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h07);
    quiet("R9");
    wr(2'd0, 8'h01);

    mon_off = 1;
    wr(2'd3, 8'h01);
    @(negedge clk);
    chk("R2", "pad off scl_oe", scl_oe, 0);
    chk("R2", "pad off sda_oe", sda_oe, 0);
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk("R2", "pad on scl_oe", scl_oe, 1);
    @(negedge clk);
    mon_off = 0;

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h04);
    quiet("R10");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h55);
    quiet("R10");
    wr(2'd0, 8'h01);

    do_byte(8'h81, 1'b1, "byte 81");
    do_byte(8'h00, 1'b0, "byte 00");
    push(EV_B0, "R5"); push(EV_STOP, "R5");
    do_cmd(2'd2, 1'b0, "stop2");

    repeat (10) @(negedge clk);
    chk("R6", "expected events left", exp_ev.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule